// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block is a combinational word shifter for an integer datapath. The shift amount comes from a general register. It can shift left, shift right logically, shift right arithmetically or rotate right, and it produces the shifter carry that the flag logic downstream may latch. Amounts of 32 and above follow fixed saturation rules instead of wrapping. This lets a shift whose count is read from a register behave the same way at every count value.

The datapath is a logarithmic barrel: one stage per bit of the in-word amount. A separate saturation path handles counts from one word width up to 255. The incoming carry flag is returned unchanged when the effective amount is zero.

Top module: `regshift`

## Requirements
- R1: The effective amount is bits [7:0] of `amt_reg`. Bits [31:8] have no effect on `dout` or `cout`.
- R2: With an effective amount of 0, every shift type returns `dout` = `din` and `cout` = `cin`.
- R3: `op`=0 is logical left. For amounts 1..31, `dout` = `din` shifted left with zero fill and `cout` = `din[32-amount]`. At exactly 32, `dout` = 0 and `cout` = `din[0]`. Above 32, `dout` = 0 and `cout` = 0.
- R4: `op`=1 is logical right. For amounts 1..31, `dout` = `din` shifted right with zero fill and `cout` = `din[amount-1]`. At exactly 32, `dout` = 0 and `cout` = `din[31]`. Above 32, `dout` = 0 and `cout` = 0.
- R5: `op`=2 is arithmetic right. For amounts 1..31, `dout` is `din` shifted right with sign fill and `cout` = `din[amount-1]`. At 32 or more, every bit of `dout` equals `din[31]` and `cout` = `din[31]`.
- R6: `op`=3 is rotate right by the amount's low 5 bits. When those bits (r) are nonzero, `dout` is `din` rotated right by r and `cout` = `din[r-1]`.
- R7: `op`=3 with low 5 amount bits zero and a nonzero 8-bit amount gives `dout` = `din` and `cout` = `din[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to shift |
| amt_reg | input | 32 | Register supplying the shift count; low 8 bits used |
| op | input | 2 | Shift type: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| cin | input | 1 | Current carry flag |
| dout | output | 32 | Shifted word |
| cout | output | 1 | New carry |

## Verification
The bench sweeps every 8-bit amount for every shift type over several data words, including all-zero, all-one and sign-boundary words. This covers the counts 0, 31, 32, 33 and 255 where the rules change. A design that wrapped the amount modulo 32 for the plain shifts would return the input at count 32 instead of zero. One that took the carry from the wrong end at exactly 32 would flip `cout` for words whose end bits differ. A rotate that ignored the zero-low-bits case would keep the old carry at counts 32, 64 and so on, instead of copying bit 31. Random upper bits in `amt_reg` would expose any decode that reads past bit 7.

// File: rtl/regshift.sv
module regshift #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] amt_reg,
  input  logic [1:0]    op,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  localparam int SW = $clog2(DW);
  localparam logic [1:0] OP_LSL = 2'd0, OP_LSR = 2'd1, OP_ASR = 2'd2, OP_ROR = 2'd3;

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) flip[i] = v[DW-1-i];
  endfunction

  logic [AW-1:0] amt;
  logic [SW-1:0] lo, lom1;
  logic          big, exact, fill;
  logic [DW-1:0] norm, small_res;
  logic          small_cy;
  logic [DW-1:0] stg [SW+1];

  assign amt   = amt_reg[AW-1:0];
  assign lo    = amt[SW-1:0];
  assign lom1  = lo - SW'(1);
  assign big   = amt >= AW'(DW);
  assign exact = amt == AW'(DW);
  assign norm  = (op == OP_LSL) ? flip(din) : din;
  assign fill  = (op == OP_ASR) ? din[DW-1] : 1'b0;
  assign stg[0] = norm;

  genvar g;
  generate
    for (g = 0; g < SW; g++) begin : g_stage
      localparam int K = 1 << g;
      assign stg[g+1] = !lo[g]         ? stg[g] :
                        (op == OP_ROR) ? {stg[g][K-1:0], stg[g][DW-1:K]} :
                                         {{K{fill}}, stg[g][DW-1:K]};
    end
  endgenerate

  assign small_res = (op == OP_LSL) ? flip(stg[SW]) : stg[SW];
  assign small_cy  = norm[lom1];

  always_comb begin
    dout = small_res;
    cout = small_cy;
    if (amt == '0) begin
      dout = din;
      cout = cin;
    end else if (op == OP_ASR && big) begin
      dout = {DW{din[DW-1]}};
      cout = din[DW-1];
    end else if (op != OP_ROR && op != OP_ASR && big) begin
      dout = '0;
      cout = exact ? small_cy : 1'b0;
    end
  end

  always_comb begin
    if (amt == '0) begin
      AST_ZERO_PASS: assert (dout == din && cout == cin); // R2
    end
    if (amt != '0 && big && (op == OP_LSL || op == OP_LSR)) begin
      AST_LOGIC_SAT: assert (dout == '0); // R3
    end
    if (amt != '0 && big && op == OP_ASR) begin
      AST_ASR_SAT: assert (dout == {DW{din[DW-1]}} && cout == din[DW-1]); // R5
    end
    if (op == OP_ROR) begin
      AST_ROR_POP: assert ($countones(dout) == $countones(din)); // R6
    end
    if (op == OP_ROR && amt != '0 && lo == '0) begin
      AST_ROR_WRAP: assert (dout == din && cout == din[DW-1]); // R7
    end
  end
endmodule

// File: tb/test_regshift.sv
module test_regshift;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [31:0] din, amt_reg, dout;
  logic [1:0]  op;
  logic        cin, cout;
  int nvec = 0, nbad = 0;

  regshift i_regshift (.din(din), .amt_reg(amt_reg), .op(op), .cin(cin), .dout(dout), .cout(cout));

  function automatic string tag(input logic [1:0] o, input int a);
    if (a == 0) return "R2";
    case (o)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return ((a % 32) == 0) ? "R7" : "R6";
    endcase
  endfunction

  task automatic expect_of(input logic [31:0] d, input logic [1:0] o, input int a, input logic c,
                           output logic [31:0] er, output logic ec);
    int r;
    er = d; ec = c;
    if (a == 0) return;
    case (o)
      2'd0: begin er = (a >= 32) ? 32'h0 : d << a;
                  ec = (a > 32) ? 1'b0 : d[32-a]; end
      2'd1: begin er = (a >= 32) ? 32'h0 : d >> a;
                  ec = (a > 32) ? 1'b0 : d[a-1]; end
      2'd2: begin er = $signed(d) >>> ((a >= 32) ? 31 : a);
                  ec = (a >= 32) ? d[31] : d[a-1]; end
      default: begin r = a % 32;
                  if (r == 0) begin er = d; ec = d[31]; end
                  else begin er = (d >> r) | (d << (32 - r)); ec = d[r-1]; end
               end
    endcase
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] ar, input logic [1:0] o,
                       input logic c, input string t);
    logic [31:0] er; logic ec;
    @(posedge clk);
    din = d; amt_reg = ar; op = o; cin = c;
    expect_of(d, o, int'(ar[7:0]), c, er, ec);
    @(negedge clk);
    nvec++;
    if (dout !== er || cout !== ec) begin
      nbad++;
      $display("FAIL %s op=%0d amt=%0d din=%h: dout=%h cout=%b expected dout=%h cout=%b",
               t, o, ar[7:0], d, dout, cout, er, ec);
    end
  endtask

  logic [31:0] pats [8] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
                            32'hA5C3_0F96, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678};

  initial begin
    din = '0; amt_reg = '0; op = '0; cin = 1'b0;
    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < 256; a++)
          apply(pats[p], {$urandom() & 32'hFFFF_FF00} | 32'(a), 2'(o),
                1'(a ^ p), tag(2'(o), a));
    // R1: upper register bits set, including amounts whose low byte is zero
    for (int k = 0; k < 64; k++)
      apply($urandom(), 32'hFFFF_FF00 | 32'(k * 4), 2'(k % 4), 1'(k), "R1");
    for (int k = 0; k < 200; k++)
      apply($urandom(), $urandom(), 2'(k % 4), 1'(k / 4), "R1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule